// File: doc/BRIEF.md
# DRAM Low-Power Sequencer

This block sits beside the access path of a DRAM controller. It watches transfer activity and, once the memory has been idle for a programmable time, places the device in one of three low-power states: self-refresh, power-down or deep power-down. It drives the clock-enable pin (CKE) of the memory and a gate for the memory clock. It also emits a one-cycle command strobe with a command type whenever it enters or leaves a state. The command layer turns that strobe into real DRAM commands.

A new access request wakes the device. The block raises CKE at once and opens the clock. It then holds its ready output low until the exit delay has run out. The delay depends on the state being left and on whether the first access is a read. After the access completes and the bus goes idle again, the same timeout starts over and the device returns to the selected state. Deep power-down is left only through reset. All configuration comes in as static inputs.

Top module: `dram_lp_ctrl`

## Requirements
- R1: While and after a synchronous reset, mem_cke=1, mem_clk_en=1, acc_ready=1 and cmd_valid=0.
- R2: With cfg_mode=0 the block never leaves the running state: mem_cke stays 1 however long the bus is idle, and no command is issued.
- R3: A clock edge is idle when xfer_busy=0 and req_valid=0. The timeout code gives N: 0 gives 0, 1 gives 64, and 2 or 3 give 128. mem_cke falls after N+1 consecutive idle edges. Any non-idle edge restarts the count from zero.
- R4: cfg_mode=1 selects self-refresh. Entry strobes cmd_valid with cmd_type=1, drives mem_cke=0, and drives mem_clk_en=0 whatever the freeze bit holds.
- R5: cfg_mode=2 selects power-down and cfg_mode=3 selects deep power-down. Entry strobes cmd_type=2 or 3 and drives mem_cke=0. mem_clk_en is 0 only while cfg_clk_freeze=1.
- R6: A request during self-refresh strobes cmd_type=4 and raises mem_cke and mem_clk_en on the wake edge. acc_ready rises cfg_t_sr_read edges later for a read and cfg_t_sr_nonread edges later for any other access.
- R7: A request during power-down strobes cmd_type=5 and raises mem_cke on the wake edge. acc_ready rises after cfg_t_pd_exit edges for a non-read. For a read it rises after cfg_t_rd_fast edges when cfg_slow_exit=0, and after cfg_t_rd_slow edges when cfg_slow_exit=1. A delay of 0 gives ready right after the wake edge.
- R8: acc_ready is 0 whenever mem_cke is 0, and stays 0 while an exit delay is still counting.
- R9: In deep power-down, requests are ignored: mem_cke and acc_ready stay 0 and no command is issued until reset, which restores the R1 values.
- R10: After every access the block goes back to the selected low-power state, using the same timeout, once the bus is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Low-power state select: 0 off, 1 self-refresh, 2 power-down, 3 deep power-down |
| cfg_timeout | input | 2 | Idle timeout code: 0 immediate, 1 64 cycles, 2 and 3 128 cycles |
| cfg_clk_freeze | input | 1 | Stop the memory clock during power-down states |
| cfg_slow_exit | input | 1 | Use the slow read delay when leaving power-down |
| cfg_t_pd_exit | input | 4 | Power-down exit delay before a non-read |
| cfg_t_sr_nonread | input | 8 | Self-refresh exit delay before a non-read |
| cfg_t_sr_read | input | 8 | Self-refresh exit delay before a read |
| cfg_t_rd_fast | input | 4 | Power-down fast-exit delay before a read |
| cfg_t_rd_slow | input | 4 | Power-down slow-exit delay before a read |
| xfer_busy | input | 1 | A transfer is in progress |
| req_valid | input | 1 | A new access is waiting |
| req_is_read | input | 1 | The waiting access is a read |
| acc_ready | output | 1 | The access path may issue commands |
| mem_cke | output | 1 | Memory clock-enable pin |
| mem_clk_en | output | 1 | Gate for the memory clock |
| cmd_valid | output | 1 | One-cycle strobe for a state-change command |
| cmd_type | output | 3 | Command: 1 enter self-refresh, 2 enter power-down, 3 enter deep power-down, 4 leave self-refresh, 5 leave power-down |

## Verification
Entry is timed under each timeout code, including reserved code 3 and an idle stretch cut short by a transfer. The test therefore shows whether the count saturates, wraps or fails to restart. Wakes are driven as reads and non-reads out of both self-refresh and power-down, with fast and slow exit and a zero delay. Each wake has a distinct delay value, so choosing the wrong timer shows up as a wrong cycle count. A scoreboard matches every command strobe against the expected sequence, so a stray command during deep power-down or with the block off is reported.

// File: rtl/dlp_pkg.sv
package dlp_pkg;

    localparam int SHORT_W   = 4;
    localparam int LONG_W    = 8;
    localparam int IDLE_STEP = 64;
    localparam int IDLE_W    = $clog2(2 * IDLE_STEP + 1);

    typedef enum logic [1:0] {
        LPM_OFF  = 2'd0,
        LPM_SELF = 2'd1,
        LPM_PDN  = 2'd2,
        LPM_DEEP = 2'd3
    } lp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_WAKE
    } ctl_state_e;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_SR_IN  = 3'd1,
        CMD_PD_IN  = 3'd2,
        CMD_DPD_IN = 3'd3,
        CMD_SR_OUT = 3'd4,
        CMD_PD_OUT = 3'd5
    } lp_cmd_e;

    typedef struct packed {
        logic               slow_exit;
        logic [SHORT_W-1:0] t_pd_exit;
        logic [LONG_W-1:0]  t_sr_nonread;
        logic [LONG_W-1:0]  t_sr_read;
        logic [SHORT_W-1:0] t_rd_fast;
        logic [SHORT_W-1:0] t_rd_slow;
    } exit_cfg_t;

    // Idle edges that must pass before entry; code 3 is treated like code 2.
    function automatic logic [IDLE_W-1:0] idle_limit(input logic [1:0] code);
        case (code)
            2'd0:    return '0;
            2'd1:    return IDLE_W'(IDLE_STEP);
            default: return IDLE_W'(2 * IDLE_STEP);
        endcase
    endfunction

    function automatic lp_cmd_e entry_cmd(input lp_mode_e m);
        case (m)
            LPM_SELF: return CMD_SR_IN;
            LPM_PDN:  return CMD_PD_IN;
            LPM_DEEP: return CMD_DPD_IN;
            default:  return CMD_NONE;
        endcase
    endfunction

    function automatic lp_cmd_e leave_cmd(input lp_mode_e m);
        return (m == LPM_SELF) ? CMD_SR_OUT : CMD_PD_OUT;
    endfunction

    function automatic logic [LONG_W-1:0] wake_delay(input lp_mode_e  kind,
                                                     input logic      rd,
                                                     input exit_cfg_t c);
        logic [SHORT_W-1:0] short_sel;
        short_sel = rd ? (c.slow_exit ? c.t_rd_slow : c.t_rd_fast) : c.t_pd_exit;
        case (kind)
            LPM_SELF: return rd ? c.t_sr_read : c.t_sr_nonread;
            LPM_PDN:  return {{(LONG_W - SHORT_W){1'b0}}, short_sel};
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/dlp_idle_timer.sv
module dlp_idle_timer
    import dlp_pkg::*;
#(
    parameter int CNT_W = IDLE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  logic             activity,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !armed || activity) begin
            cnt <= '0;
        end else if (cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = armed && !activity && (cnt >= limit);

    // R3: any busy edge clears the idle count
    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        activity |=> (cnt == '0))
        else $error("idle count not restarted by activity");

    // R3: the count never runs past the limit while the limit holds
    a_r3_no_overrun: assert property (@(posedge clk) disable iff (rst)
        ($stable(limit) && cnt <= limit) |=> (cnt <= limit))
        else $error("idle count ran past the limit");

endmodule

// File: rtl/dlp_exit_timer.sv
module dlp_exit_timer
    import dlp_pkg::*;
#(
    parameter int W = LONG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R8: the exit delay drains by exactly one per cycle
    a_r8_countdown: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1))
        else $error("exit delay did not step down by one");

endmodule

// File: rtl/dram_lp_ctrl.sv
module dram_lp_ctrl
    import dlp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cfg_mode,
    input  logic [1:0]         cfg_timeout,
    input  logic               cfg_clk_freeze,
    input  logic               cfg_slow_exit,
    input  logic [SHORT_W-1:0] cfg_t_pd_exit,
    input  logic [LONG_W-1:0]  cfg_t_sr_nonread,
    input  logic [LONG_W-1:0]  cfg_t_sr_read,
    input  logic [SHORT_W-1:0] cfg_t_rd_fast,
    input  logic [SHORT_W-1:0] cfg_t_rd_slow,
    input  logic               xfer_busy,
    input  logic               req_valid,
    input  logic               req_is_read,
    output logic               acc_ready,
    output logic               mem_cke,
    output logic               mem_clk_en,
    output logic               cmd_valid,
    output logic [2:0]         cmd_type
);

    ctl_state_e state_q;
    lp_mode_e   kind_q;
    lp_cmd_e    cmd_q;
    logic       cmd_v_q;

    exit_cfg_t  ecfg;
    lp_mode_e   mode_sel;
    logic       activity;
    logic       idle_expired;
    logic       entry_go;
    logic       wake_go;
    logic       exit_done;
    logic [LONG_W-1:0] delay_sel;

    assign mode_sel = lp_mode_e'(cfg_mode);
    assign activity = xfer_busy | req_valid;

    always_comb begin
        ecfg.slow_exit    = cfg_slow_exit;
        ecfg.t_pd_exit    = cfg_t_pd_exit;
        ecfg.t_sr_nonread = cfg_t_sr_nonread;
        ecfg.t_sr_read    = cfg_t_sr_read;
        ecfg.t_rd_fast    = cfg_t_rd_fast;
        ecfg.t_rd_slow    = cfg_t_rd_slow;
    end

    dlp_idle_timer #(.CNT_W(IDLE_W)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .armed    (state_q == ST_RUN),
        .activity (activity),
        .limit    (idle_limit(cfg_timeout)),
        .expired  (idle_expired)
    );

    assign entry_go  = idle_expired && (mode_sel != LPM_OFF);
    assign wake_go   = (state_q == ST_SLEEP) && req_valid && (kind_q != LPM_DEEP);
    assign delay_sel = wake_delay(kind_q, req_is_read, ecfg);

    dlp_exit_timer #(.W(LONG_W)) u_exit (
        .clk      (clk),
        .rst      (rst),
        .load     (wake_go),
        .load_val (delay_sel),
        .done     (exit_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            kind_q  <= LPM_OFF;
            cmd_q   <= CMD_NONE;
            cmd_v_q <= 1'b0;
        end else begin
            cmd_v_q <= 1'b0;
            cmd_q   <= CMD_NONE;
            case (state_q)
                ST_RUN: begin
                    if (entry_go) begin
                        state_q <= ST_SLEEP;
                        kind_q  <= mode_sel;
                        cmd_q   <= entry_cmd(mode_sel);
                        cmd_v_q <= 1'b1;
                    end
                end
                ST_SLEEP: begin
                    if (wake_go) begin
                        state_q <= ST_WAKE;
                        cmd_q   <= leave_cmd(kind_q);
                        cmd_v_q <= 1'b1;
                    end
                end
                ST_WAKE: begin
                    if (exit_done) begin
                        state_q <= ST_RUN;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    assign mem_cke    = (state_q != ST_SLEEP);
    assign mem_clk_en = !((state_q == ST_SLEEP) &&
                          ((kind_q == LPM_SELF) || cfg_clk_freeze));
    assign acc_ready  = (state_q == ST_RUN) || ((state_q == ST_WAKE) && exit_done);
    assign cmd_valid  = cmd_v_q;
    assign cmd_type   = cmd_q;

    // R4/R5: the clock is only ever stopped with CKE low
    a_r5_gate_needs_cke: assert property (@(posedge clk) disable iff (rst)
        !mem_clk_en |-> !mem_cke)
        else $error("memory clock stopped with CKE high");

    // R8: no ready while the device sleeps
    a_r8_no_ready_asleep: assert property (@(posedge clk) disable iff (rst)
        !mem_cke |-> !acc_ready)
        else $error("ready raised with CKE low");

    // R9: deep power-down is left only through reset
    a_r9_deep_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && kind_q == LPM_DEEP) |=> (state_q == ST_SLEEP))
        else $error("deep power-down left without reset");

    // R2: with the feature off the device stays awake
    a_r2_off_awake: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && mode_sel == LPM_OFF) |=> mem_cke)
        else $error("low-power entry with mode off");

    // R6/R7: a wake raises CKE and strobes a leave command
    a_r6_wake_strobe: assert property (@(posedge clk) disable iff (rst)
        wake_go |=> (cmd_valid && mem_cke))
        else $error("wake without command strobe");

endmodule

// File: tb/dram_lp_ctrl_tb.sv
module dram_lp_ctrl_tb;
    import dlp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic [1:0] cfg_timeout = 2'd0;
    logic       cfg_clk_freeze = 1'b0;
    logic       cfg_slow_exit = 1'b0;
    logic [3:0] cfg_t_pd_exit = 4'd3;
    logic [7:0] cfg_t_sr_nonread = 8'd9;
    logic [7:0] cfg_t_sr_read = 8'd5;
    logic [3:0] cfg_t_rd_fast = 4'd2;
    logic [3:0] cfg_t_rd_slow = 4'd7;
    logic       xfer_busy = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_is_read = 1'b0;
    logic       acc_ready, mem_cke, mem_clk_en, cmd_valid;
    logic [2:0] cmd_type;

    int  nvec = 0;
    int  nbad = 0;
    bit  finished = 1'b0;
    lp_cmd_e exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_lp_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_timeout(cfg_timeout),
        .cfg_clk_freeze(cfg_clk_freeze), .cfg_slow_exit(cfg_slow_exit),
        .cfg_t_pd_exit(cfg_t_pd_exit), .cfg_t_sr_nonread(cfg_t_sr_nonread),
        .cfg_t_sr_read(cfg_t_sr_read), .cfg_t_rd_fast(cfg_t_rd_fast),
        .cfg_t_rd_slow(cfg_t_rd_slow), .xfer_busy(xfer_busy),
        .req_valid(req_valid), .req_is_read(req_is_read),
        .acc_ready(acc_ready), .mem_cke(mem_cke), .mem_clk_en(mem_clk_en),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor: every command strobe must match the next expected item
    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R9 unexpected command", int'(cmd_type), 0);
            end else begin
                lp_cmd_e e;
                e = exp_q.pop_front();
                check(cmd_type == e, "R4/R5/R6/R7 command type", int'(cmd_type), int'(e));
            end
        end
    end

    task automatic go_sleep(input int n_lim, input lp_cmd_e c, input bit clk_exp,
                            input string tag);
        int n;
        exp_q.push_back(c);
        xfer_busy = 1'b1;
        tick();
        xfer_busy = 1'b0;
        n = 0;
        while (mem_cke && n < 400) begin
            tick();
            n++;
        end
        check(n == n_lim + 1, {tag, " entry edges"}, n, n_lim + 1);
        check(mem_clk_en == clk_exp, {tag, " clock gate"}, int'(mem_clk_en), int'(clk_exp));
        check(acc_ready == 1'b0, "R8 ready while asleep", int'(acc_ready), 0);
    endtask

    task automatic wake(input bit rd, input int d_exp, input lp_cmd_e c, input string tag);
        int n;
        exp_q.push_back(c);
        req_valid   = 1'b1;
        req_is_read = rd;
        tick();
        check(mem_cke == 1'b1, {tag, " cke on wake"}, int'(mem_cke), 1);
        check(mem_clk_en == 1'b1, {tag, " clock on wake"}, int'(mem_clk_en), 1);
        n = 0;
        while (!acc_ready && n < 400) begin
            tick();
            n++;
        end
        check(n == d_exp, {tag, " exit delay"}, n, d_exp);
        req_valid   = 1'b0;
        req_is_read = 1'b0;
        xfer_busy   = 1'b1;
        tick();
        tick();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) tick();
        check(mem_cke == 1'b1 && acc_ready == 1'b1, "R1 in reset", int'(mem_cke), 1);
        rst = 1'b0;
        tick();
        check(mem_cke == 1'b1, "R1 cke", int'(mem_cke), 1);
        check(mem_clk_en == 1'b1, "R1 clock", int'(mem_clk_en), 1);
        check(acc_ready == 1'b1, "R1 ready", int'(acc_ready), 1);
        check(cmd_valid == 1'b0, "R1 strobe", int'(cmd_valid), 0);

        // R2: feature off, long idle
        repeat (200) tick();
        check(mem_cke == 1'b1, "R2 cke after idle", int'(mem_cke), 1);
        check(acc_ready == 1'b1, "R2 ready after idle", int'(acc_ready), 1);

        // R4 / R6 / R10: self-refresh, immediate timeout
        xfer_busy = 1'b1;
        cfg_mode  = 2'd1;
        cfg_timeout = 2'd0;
        go_sleep(0, CMD_SR_IN, 1'b0, "R4 self-refresh");
        wake(1'b1, 5, CMD_SR_OUT, "R6 read");
        go_sleep(0, CMD_SR_IN, 1'b0, "R10 re-entry");
        wake(1'b0, 9, CMD_SR_OUT, "R6 non-read");

        // R3 / R5 / R7: power-down with each timeout code
        cfg_mode = 2'd2;
        cfg_timeout = 2'd1;
        go_sleep(64, CMD_PD_IN, 1'b1, "R3 code1 R5");
        wake(1'b0, 3, CMD_PD_OUT, "R7 non-read");
        cfg_timeout = 2'd2;
        cfg_clk_freeze = 1'b1;
        go_sleep(128, CMD_PD_IN, 1'b0, "R5 freeze");
        wake(1'b1, 2, CMD_PD_OUT, "R7 fast read");
        cfg_timeout = 2'd3;
        cfg_clk_freeze = 1'b0;
        cfg_slow_exit = 1'b1;
        go_sleep(128, CMD_PD_IN, 1'b1, "R3 code3");
        wake(1'b1, 7, CMD_PD_OUT, "R7 slow read");

        // R3: partial idle stretch then restart
        cfg_timeout = 2'd1;
        xfer_busy = 1'b0;
        repeat (40) tick();
        check(mem_cke == 1'b1, "R3 partial idle", int'(mem_cke), 1);
        go_sleep(64, CMD_PD_IN, 1'b1, "R3 restart");
        cfg_t_pd_exit = 4'd0;
        wake(1'b0, 0, CMD_PD_OUT, "R7 zero delay");

        // R9: deep power-down ignores requests
        cfg_mode = 2'd3;
        cfg_timeout = 2'd0;
        go_sleep(0, CMD_DPD_IN, 1'b1, "R9 deep");
        req_valid = 1'b1;
        repeat (20) tick();
        check(mem_cke == 1'b0, "R9 cke held low", int'(mem_cke), 0);
        check(acc_ready == 1'b0, "R9 ready held low", int'(acc_ready), 0);
        rst = 1'b1;
        cfg_mode = 2'd0;
        tick();
        check(mem_cke == 1'b1, "R9 reset cke", int'(mem_cke), 1);
        check(acc_ready == 1'b1, "R9 reset ready", int'(acc_ready), 1);
        rst = 1'b0;
        req_valid = 1'b0;
        repeat (3) tick();

        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule